// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level table kept in memory. A client presents the address together with the current table base; the walker fetches a first-level descriptor, and that descriptor either ends the walk with a 1 MB mapping, sends it to a second-level table, or reports a fault. A second-level descriptor ends the walk with a 64 KB mapping, a 4 KB mapping or a fault.

The walker is strictly sequential. It has one outstanding descriptor read at a time on a single-port read interface and waits any number of cycles for the read data. One translation is in flight at a time. The result is held on the response port until the client takes it.

Top module: `pgw_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_req_o` is 0.
- R2: A request is taken only when `req_ready_o` is 1. From the edge that takes it until the response is consumed, `req_ready_o` stays 0 and any further `req_valid_i` is ignored.
- R3: The first read goes to address {ttb_i[31:14], va[31:20], 2'b00}. Each read is a `mem_req_o` pulse of exactly one cycle, and `mem_req_o` stays low while the walker waits for data.
- R4: A first-level descriptor with bits [1:0] = 2'b10 completes the walk after one read, with pa = {desc[31:20], va[19:0]} and `rsp_size_o` = 2'b10.
- R5: A first-level descriptor with bits [1:0] = 2'b00 or 2'b11 completes the walk after one read, with `rsp_fault_o` = 1, pa = 0 and `rsp_size_o` = 2'b11.
- R6: A first-level descriptor with bits [1:0] = 2'b01 causes a second read at address {desc[31:10], 10'b0} + {va[19:12], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 2'b01 gives pa = {desc[31:16], va[15:0]} and `rsp_size_o` = 2'b01.
- R8: A second-level descriptor with bit 1 set gives pa = {desc[31:12], va[11:0]} and `rsp_size_o` = 2'b00.
- R9: A second-level descriptor with bits [1:0] = 2'b00 gives `rsp_fault_o` = 1, pa = 0 and `rsp_size_o` = 2'b11.
- R10: `rsp_valid_o`, `rsp_pa_o`, `rsp_fault_o` and `rsp_size_o` hold steady while `rsp_ready_i` is 0. The cycle after a response is taken, `rsp_valid_o` is 0 and `req_ready_o` is 1.
- R11: `mem_rvalid_i` has no effect unless a descriptor read is pending. When the walker is idle, a pulse on it starts no read and produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker can take a request |
| req_va_i | input | 32 | Virtual address to translate |
| ttb_i | input | 32 | Table base; bits [31:14] are used |
| rsp_valid_o | output | 1 | Result available |
| rsp_ready_i | input | 1 | Client takes the result |
| rsp_pa_o | output | 32 | Physical address, zero on fault |
| rsp_fault_o | output | 1 | Walk ended on a non-resident descriptor |
| rsp_size_o | output | 2 | 00 = 4 KB, 01 = 64 KB, 10 = 1 MB, 11 = fault |
| mem_req_o | output | 1 | One-cycle descriptor read strobe |
| mem_addr_o | output | 32 | Descriptor address, word aligned |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor word |

## Verification
The walker is driven across several table bases, including all-zero and all-one upper bits, and hundreds of virtual addresses. The memory model returns a word derived arithmetically from the address, so the descriptor type codes fall on every outcome. A coverage check confirms that section, large-page, small-page and both fault kinds each occurred. Read latency and response back-pressure are varied from walk to walk. These variations separate a walker that samples data early or drifts its output from one that waits and holds correctly. Some walks keep a second request asserted while busy, and one idle pulse on the read-valid input exposes logic that acts outside a pending read.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned AW         = 32;
  localparam int unsigned L1_LSB     = 20;
  localparam int unsigned L2_LSB     = 12;
  localparam int unsigned LARGE_LSB  = 16;
  localparam int unsigned L1_IDX_W   = AW - L1_LSB;
  localparam int unsigned L2_IDX_W   = L1_LSB - L2_LSB;
  localparam int unsigned TBL_LSB    = L1_IDX_W + 2;
  localparam int unsigned PTR_LSB    = L2_IDX_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_RD, ST_L1_WT, ST_L2_RD, ST_L2_WT, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    SZ_4K   = 2'b00,
    SZ_64K  = 2'b01,
    SZ_1M   = 2'b10,
    SZ_NONE = 2'b11
  } pg_size_e;

  typedef enum logic [1:0] {
    K_FAULT, K_NEXT, K_LEAF
  } desc_kind_e;
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
(
  input  logic [AW-1:TBL_LSB] ttb_hi_i,
  input  logic [AW-1:0]       va_i,
  input  logic [AW-1:PTR_LSB] ptr_i,
  input  logic                sel_l2_i,
  output logic [AW-1:0]       addr_o
);
  logic [AW-1:0] l1_addr, l2_addr;
  logic          unused_va;

  assign l1_addr = {ttb_hi_i, va_i[AW-1:L1_LSB], 2'b00};
  assign l2_addr = {ptr_i, {PTR_LSB{1'b0}}}
                 + {{(AW-PTR_LSB){1'b0}}, va_i[L1_LSB-1:L2_LSB], 2'b00};
  assign addr_o  = sel_l2_i ? l2_addr : l1_addr;
  assign unused_va = ^va_i[L2_LSB-1:0];
endmodule

// File: rtl/pgw_desc_decode.sv
module pgw_desc_decode
  import pgw_pkg::*;
#(
  parameter int unsigned LEVEL = 1
) (
  input  logic [AW-1:0]       desc_i,
  input  logic [AW-1:0]       va_i,
  output desc_kind_e          kind_o,
  output logic [AW-1:0]       pa_o,
  output pg_size_e            size_o,
  output logic [AW-1:PTR_LSB] ptr_o
);
  generate
    if (LEVEL == 1) begin : g_l1
      logic unused_l1;
      assign unused_l1 = ^{desc_i[PTR_LSB-1:2], va_i[AW-1:L1_LSB]};
      assign ptr_o     = desc_i[AW-1:PTR_LSB];
      always_comb begin
        kind_o = K_FAULT;
        pa_o   = '0;
        size_o = SZ_NONE;
        unique case (desc_i[1:0])
          2'b10: begin
            kind_o = K_LEAF;
            pa_o   = {desc_i[AW-1:L1_LSB], va_i[L1_LSB-1:0]};
            size_o = SZ_1M;
          end
          2'b01: kind_o = K_NEXT;
          default: ;
        endcase
      end
    end else begin : g_l2
      logic unused_l2;
      assign unused_l2 = ^{desc_i[L2_LSB-1:2], va_i[AW-1:L1_LSB+0]};
      assign ptr_o     = '0;
      always_comb begin
        kind_o = K_FAULT;
        pa_o   = '0;
        size_o = SZ_NONE;
        if (desc_i[1]) begin
          kind_o = K_LEAF;
          pa_o   = {desc_i[AW-1:L2_LSB], va_i[L2_LSB-1:0]};
          size_o = SZ_4K;
        end else if (desc_i[0]) begin
          kind_o = K_LEAF;
          pa_o   = {desc_i[AW-1:LARGE_LSB], va_i[LARGE_LSB-1:0]};
          size_o = SZ_64K;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_va_i,
  input  logic [31:0]   ttb_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [31:0]   rsp_pa_o,
  output logic          rsp_fault_o,
  output logic [1:0]    rsp_size_o,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i
);
  walk_state_e         state_q, state_d;
  logic [AW-1:0]       va_q, va_d;
  logic [AW-1:TBL_LSB] ttb_q, ttb_d;
  logic [AW-1:PTR_LSB] ptr_q, ptr_d;
  logic [AW-1:0]       pa_q, pa_d;
  logic                fault_q, fault_d;
  pg_size_e            size_q, size_d;
  logic                unused_ttb;

  desc_kind_e          kind   [2];
  logic [AW-1:0]       lvl_pa [2];
  pg_size_e            lvl_sz [2];
  logic [AW-1:PTR_LSB] lvl_ptr[2];

  assign unused_ttb = ^ttb_i[TBL_LSB-1:0];

  pgw_addr_gen u_addr (
    .ttb_hi_i (ttb_q),
    .va_i     (va_q),
    .ptr_i    (ptr_q),
    .sel_l2_i (state_q == ST_L2_RD),
    .addr_o   (mem_addr_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    pgw_desc_decode #(.LEVEL(g + 1)) u_dec (
      .desc_i (mem_rdata_i),
      .va_i   (va_q),
      .kind_o (kind[g]),
      .pa_o   (lvl_pa[g]),
      .size_o (lvl_sz[g]),
      .ptr_o  (lvl_ptr[g])
    );
  end

  always_comb begin
    state_d = state_q;
    va_d    = va_q;
    ttb_d   = ttb_q;
    ptr_d   = ptr_q;
    pa_d    = pa_q;
    fault_d = fault_q;
    size_d  = size_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        va_d    = req_va_i;
        ttb_d   = ttb_i[AW-1:TBL_LSB];
        state_d = ST_L1_RD;
      end
      ST_L1_RD: state_d = ST_L1_WT;
      ST_L1_WT: if (mem_rvalid_i) begin
        if (kind[0] == K_NEXT) begin
          ptr_d   = lvl_ptr[0];
          state_d = ST_L2_RD;
        end else begin
          pa_d    = lvl_pa[0];
          size_d  = lvl_sz[0];
          fault_d = (kind[0] == K_FAULT);
          state_d = ST_DONE;
        end
      end
      ST_L2_RD: state_d = ST_L2_WT;
      ST_L2_WT: if (mem_rvalid_i) begin
        pa_d    = lvl_pa[1];
        size_d  = lvl_sz[1];
        fault_d = (kind[1] == K_FAULT);
        state_d = ST_DONE;
      end
      ST_DONE: if (rsp_ready_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      ttb_q   <= '0;
      ptr_q   <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      size_q  <= SZ_NONE;
    end else begin
      state_q <= state_d;
      va_q    <= va_d;
      ttb_q   <= ttb_d;
      ptr_q   <= ptr_d;
      pa_q    <= pa_d;
      fault_q <= fault_d;
      size_q  <= size_d;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_L1_RD) || (state_q == ST_L2_RD);
  assign rsp_valid_o = (state_q == ST_DONE);
  assign rsp_pa_o    = pa_q;
  assign rsp_fault_o = fault_q;
  assign rsp_size_o  = size_q;

  a_r2_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  a_r3_strobe_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r3_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);
  a_r5_fault_zeroed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_pa_o == '0 && rsp_size_o == SZ_NONE);
  a_r4_leaf_has_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_size_o != SZ_NONE);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o)
                                    && $stable(rsp_fault_o) && $stable(rsp_size_o));
  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i |=> !rsp_valid_o && req_ready_o);
  a_r11_no_strobe_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_o);
endmodule

// File: tb/pgw_walker_tb.sv
module pgw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] req_va = '0, ttb = '0, mem_rdata = '0;
  logic        req_ready, rsp_valid, rsp_fault, mem_req;
  logic [31:0] rsp_pa, mem_addr;
  logic [1:0]  rsp_size;
  int          n_chk = 0, n_bad = 0;
  int          c_sec = 0, c_lrg = 0, c_sml = 0, c_f1 = 0, c_f2 = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  pgw_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va), .ttb_i(ttb),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_pa_o(rsp_pa),
    .rsp_fault_o(rsp_fault), .rsp_size_o(rsp_size),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ (a >> 11) ^ (a >> 5);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic walk(logic [31:0] va, logic [31:0] tb, int lat, int hold, bit poke);
    logic [31:0] d1, d2, a1, a2, epa, got_a1, got_a2, pa0;
    logic [1:0]  esz, sz0;
    logic        eflt, f0;
    int          ereads, nreads, guard;
    string       tag;
    a1 = {tb[31:14], va[31:20], 2'b00};
    d1 = mem_word(a1);
    a2 = {d1[31:10], 10'b0} + {22'b0, va[19:12], 2'b00};
    d2 = mem_word(a2);
    ereads = 1; eflt = 1'b0; epa = '0; esz = 2'b11;
    case (d1[1:0])
      2'b10: begin tag = "R4"; epa = {d1[31:20], va[19:0]}; esz = 2'b10; c_sec++; end
      2'b01: begin
        ereads = 2;
        if (d2[1]) begin tag = "R8"; epa = {d2[31:12], va[11:0]}; esz = 2'b00; c_sml++; end
        else if (d2[0]) begin tag = "R7"; epa = {d2[31:16], va[15:0]}; esz = 2'b01; c_lrg++; end
        else begin tag = "R9"; eflt = 1'b1; c_f2++; end
      end
      default: begin tag = "R5"; eflt = 1'b1; c_f1++; end
    endcase

    @(negedge clk);
    chk(req_ready, "R2 ready before request", {31'b0, req_ready}, 32'd1);
    req_valid = 1'b1; req_va = va; ttb = tb;
    @(negedge clk);
    if (poke) begin req_va = ~va; ttb = ~tb; end else req_valid = 1'b0;
    nreads = 0; guard = 0; got_a1 = '0; got_a2 = '0;
    while (!rsp_valid && guard < 100) begin
      guard++;
      chk(!req_ready, "R2 busy", {31'b0, req_ready}, 32'd0);
      if (mem_req) begin
        nreads++;
        if (nreads == 1) got_a1 = mem_addr; else got_a2 = mem_addr;
        for (int w = 0; w <= lat; w++) begin
          @(negedge clk);
          chk(!mem_req, "R3 strobe width", {31'b0, mem_req}, 32'd0);
        end
        mem_rvalid = 1'b1; mem_rdata = mem_word(nreads == 1 ? got_a1 : got_a2);
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      end else @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rsp_valid, "R10 response arrives", {31'b0, rsp_valid}, 32'd1);
    chk(nreads == ereads, {tag, " read count"}, nreads, ereads);
    chk(got_a1 == a1, "R3 first address", got_a1, a1);
    if (ereads == 2) chk(got_a2 == a2, "R6 second address", got_a2, a2);
    chk(rsp_pa == epa, {tag, " pa"}, rsp_pa, epa);
    chk(rsp_fault == eflt, {tag, " fault"}, {31'b0, rsp_fault}, {31'b0, eflt});
    chk(rsp_size == esz, {tag, " size"}, {30'b0, rsp_size}, {30'b0, esz});
    pa0 = rsp_pa; f0 = rsp_fault; sz0 = rsp_size;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == pa0 && rsp_fault == f0 && rsp_size == sz0,
          "R10 hold", rsp_pa, pa0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R10 release", {30'b0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    logic [31:0] bases [4];
    bases[0] = 32'h0000_0000; bases[1] = 32'hFFFF_C000;
    bases[2] = 32'h1234_5678; bases[3] = 32'h8000_4000;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1 reset state",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R1 after release",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'd4);
    // R11: idle read-valid pulse must do nothing
    mem_rvalid = 1'b1; mem_rdata = 32'h0000_0002;
    @(negedge clk);
    mem_rvalid = 1'b0;
    for (int q = 0; q < 3; q++) begin
      chk(req_ready && !rsp_valid && !mem_req, "R11 idle rvalid ignored",
          {29'b0, req_ready, rsp_valid, mem_req}, 32'd4);
      @(negedge clk);
    end
    for (int t = 0; t < 4; t++) begin
      walk(32'h0000_0000, bases[t], 0, 0, 1'b0);
      walk(32'hFFFF_FFFF, bases[t], 1, 1, 1'b1);
      for (int i = 0; i < 150; i++)
        walk((i * 32'h0013_5B37) ^ (t << 28) ^ (i << 20), bases[t], i % 4, i % 3, (i % 5) == 0);
    end
    chk(c_sec > 0, "R4 coverage", c_sec, 1);
    chk(c_f1 > 0, "R5 coverage", c_f1, 1);
    chk(c_lrg > 0, "R7 coverage", c_lrg, 1);
    chk(c_sml > 0, "R8 coverage", c_sml, 1);
    chk(c_f2 > 0, "R9 coverage", c_f2, 1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule